// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Interlock

This block sits beside a five-stage integer pipeline and performs 32-bit multiplication and division one bit per cycle. The execute stage hands it an operation and two operands. From that point it runs on its own, and instructions that do not use its results keep flowing through the pipeline. The unit holds two result registers. HI receives the upper product half or the remainder. LO receives the lower product half or the quotient.

The interlock protects reads of those registers. Decode raises a flag when the instruction it holds reads HI or LO. The block then requests a stall for as long as the unit is busy, or while a new operation is being launched in the same cycle. The pipeline uses that request to freeze fetch and decode and to send a bubble into execute. If a new operation is launched while one is still running, the running one is dropped and the unit starts over with the new operands.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 2'b00 is a signed multiply and 2'b01 an unsigned multiply. The 64-bit product goes to HI (bits 63..32) and LO (bits 31..0).
- R2: Op code 2'b10 is a signed divide and 2'b11 an unsigned divide, with a nonzero divisor. LO receives the quotient and HI the remainder. A signed quotient is truncated toward zero and a signed remainder carries the sign of the dividend. The case 0x80000000 / -1 gives LO = 0x80000000 and HI = 0.
- R3: A divide by zero completes normally and raises no exception. HI equals the dividend. LO is 0xFFFFFFFF, except for a signed divide with a negative dividend, which gives LO = 1.
- R4: busy_o rises on the first clock edge after a launch and stays high for exactly 33 cycles. HI and LO change only on the edge where busy_o falls, and they hold their old values before that edge.
- R5: stall_o is high whenever dec_reads_hilo_i is high and either busy_o is high or a launch is presented in the same cycle.
- R6: When dec_reads_hilo_i is low, stall_o is low, including in cycles that launch an operation.
- R7: A launch accepted while the unit is busy, including in its final cycle, abandons the running operation. That operation never writes HI or LO. The new operation completes with the normal timing of R4.
- R8: After reset, busy_o is low, HI and LO are zero, and stall_o stays low even when a read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_valid_i | input | 1 | Start an operation this cycle |
| launch_op_i | input | 2 | Operation code (see R1, R2) |
| launch_a_i | input | 32 | Multiplicand or dividend |
| launch_b_i | input | 32 | Multiplier or divisor |
| dec_reads_hilo_i | input | 1 | Decode instruction reads HI or LO |
| stall_o | output | 1 | Freeze fetch/decode and bubble execute |
| busy_o | output | 1 | Operation in progress |
| hi_o | output | 32 | HI result register |
| lo_o | output | 32 | LO result register |

## Verification
Results are due on the 33rd rising edge after the one that accepts the launch. The bench therefore drives each launch at a falling edge and samples on falling edges. It confirms that busy_o is set one sample later. It checks that HI and LO still hold their previous values 32 samples after that, and it compares them with the arithmetic results one sample later, which is also when busy_o must read low. stall_o is combinational, so the bench checks it a few nanoseconds after setting the read flag, both in the launch cycle and during the operation. Restarts are launched both in the middle of an operation and in its final cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
  parameter int W = 32
) (
  input  logic [W:0]   acc_i,
  input  logic [W-1:0] qr_i,
  input  logic [W-1:0] opnd_i,
  output logic [W:0]   acc_o,
  output logic [W-1:0] qr_o
);
  logic [W:0] sum;

  always_comb begin
    sum   = acc_i + (qr_i[0] ? {1'b0, opnd_i} : '0);
    acc_o = {1'b0, sum[W:1]};
    qr_o  = {sum[0], qr_i[W-1:1]};
  end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
  parameter int W = 32
) (
  input  logic [W:0]   acc_i,
  input  logic [W-1:0] qr_i,
  input  logic [W-1:0] opnd_i,
  output logic [W:0]   acc_o,
  output logic [W-1:0] qr_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {acc_i[W-1:0], qr_i[W-1]};
    fits    = shifted >= {1'b0, opnd_i};
    diff    = shifted - {1'b0, opnd_i};
    acc_o   = fits ? diff : shifted;
    qr_o    = {qr_i[W-2:0], fits};
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic step_o,
  output logic fix_o,
  output logic busy_o
);
  localparam int CW = $clog2(W + 1);

  md_state_e       state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      cnt_q   <= CW'(W);
    end else begin
      unique case (state_q)
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // a start overrides both the step and the final write
  assign step_o = (state_q == ST_RUN) && !start_i;
  assign fix_o  = (state_q == ST_FIX) && !start_i;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/muldiv_interlock.sv
module muldiv_interlock (
  input  logic reads_hilo_i,
  input  logic busy_i,
  input  logic launch_i,
  output logic stall_o
);
  // a launch in execute is older than the reader in decode
  assign stall_o = reads_hilo_i && (busy_i || launch_i);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         launch_valid_i,
  input  logic [1:0]   launch_op_i,
  input  logic [W-1:0] launch_a_i,
  input  logic [W-1:0] launch_b_i,
  input  logic         dec_reads_hilo_i,
  output logic         stall_o,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int PW = 2 * W;

  logic         is_signed, a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;

  logic [W:0]   acc_q;
  logic [W-1:0] qr_q, opnd_q;
  logic         is_div_q, neg_q_q, neg_a_q;
  logic [W-1:0] hi_q, lo_q;

  logic [W:0]   mul_acc, div_acc;
  logic [W-1:0] mul_qr, div_qr;
  logic         step, fix;

  logic [PW-1:0] prod_raw, prod_fix;
  logic [W-1:0]  quo_fix, rem_fix;

  always_comb begin
    is_signed = (launch_op_i == OP_MUL_S) || (launch_op_i == OP_DIV_S);
    a_neg     = is_signed && launch_a_i[W-1];
    b_neg     = is_signed && launch_b_i[W-1];
    a_mag     = a_neg ? (~launch_a_i + 1'b1) : launch_a_i;
    b_mag     = b_neg ? (~launch_b_i + 1'b1) : launch_b_i;
  end

  muldiv_seq #(.W(W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch_valid_i),
    .step_o (step),
    .fix_o  (fix),
    .busy_o (busy_o)
  );

  muldiv_mul_step #(.W(W)) u_mul (
    .acc_i (acc_q),
    .qr_i  (qr_q),
    .opnd_i(opnd_q),
    .acc_o (mul_acc),
    .qr_o  (mul_qr)
  );

  muldiv_div_step #(.W(W)) u_div (
    .acc_i (acc_q),
    .qr_i  (qr_q),
    .opnd_i(opnd_q),
    .acc_o (div_acc),
    .qr_o  (div_qr)
  );

  muldiv_interlock u_ilk (
    .reads_hilo_i(dec_reads_hilo_i),
    .busy_i      (busy_o),
    .launch_i    (launch_valid_i),
    .stall_o     (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      qr_q     <= '0;
      opnd_q   <= '0;
      is_div_q <= 1'b0;
      neg_q_q  <= 1'b0;
      neg_a_q  <= 1'b0;
    end else if (launch_valid_i) begin
      acc_q    <= '0;
      qr_q     <= a_mag;
      opnd_q   <= b_mag;
      is_div_q <= launch_op_i[1];
      neg_q_q  <= a_neg ^ b_neg;
      neg_a_q  <= a_neg;
    end else if (step) begin
      acc_q <= is_div_q ? div_acc : mul_acc;
      qr_q  <= is_div_q ? div_qr  : mul_qr;
    end
  end

  // sign fix-up on the magnitudes
  always_comb begin
    prod_raw = {acc_q[W-1:0], qr_q};
    prod_fix = neg_q_q ? (~prod_raw + 1'b1) : prod_raw;
    quo_fix  = neg_q_q ? (~qr_q + 1'b1) : qr_q;
    rem_fix  = neg_a_q ? (~acc_q[W-1:0] + 1'b1) : acc_q[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fix) begin
      hi_q <= is_div_q ? rem_fix : prod_fix[PW-1:W];
      lo_q <= is_div_q ? quo_fix : prod_fix[W-1:0];
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         launch_valid_i,
  input logic         dec_reads_hilo_i,
  input logic         stall_o,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 3);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             busy_cnt <= '0;
    else if (launch_valid_i) busy_cnt <= CW'(1);
    else if (busy_o)         busy_cnt <= busy_cnt + 1'b1;
  end

  // R5
  stall_on_busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_reads_hilo_i && (busy_o || launch_valid_i)) |-> stall_o);

  // R6
  no_stall_without_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_reads_hilo_i |-> !stall_o);

  // R4
  busy_after_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_i |=> busy_o);

  // R4
  busy_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(busy_cnt) == CW'(W + 1)));

  // R4
  hi_change_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hi_o) |-> $fell(busy_o));

  // R4
  lo_change_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lo_o) |-> $fell(busy_o));

  // R7
  restart_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_i |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .launch_valid_i  (launch_valid_i),
  .dec_reads_hilo_i(dec_reads_hilo_i),
  .stall_o         (stall_o),
  .busy_o          (busy_o),
  .hi_o            (hi_o),
  .lo_o            (lo_o)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         launch_valid_i = 1'b0;
  logic [1:0]   launch_op_i = 2'b00;
  logic [W-1:0] launch_a_i = '0;
  logic [W-1:0] launch_b_i = '0;
  logic         dec_reads_hilo_i = 1'b0;
  logic         stall_o, busy_o;
  logic [W-1:0] hi_o, lo_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_hi = '0;
  logic [W-1:0] exp_lo = '0;

  always #2 clk_i = ~clk_i;

  muldiv_unit #(.W(W)) u_muldiv_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    longint sa, sb, sp;
    logic [63:0] up;
    logic [31:0] q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin sp = sa * sb; return sp; end
      2'b01: begin up = {32'b0, a} * {32'b0, b}; return up; end
      2'b10: begin
        if (b == 0) begin q = a[31] ? 32'd1 : 32'hFFFF_FFFF; r = a; end
        else begin q = 32'(sa / sb); r = 32'(sa % sb); end
        return {r, q};
      end
      default: begin
        if (b == 0) begin q = 32'hFFFF_FFFF; r = a; end
        else begin q = a / b; r = a % b; end
        return {r, q};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic [31:0] b);
    if (!op[1]) return "R1";
    if (b == 0) return "R3";
    return "R2";
  endfunction

  // caller is at a falling edge; returns at the falling edge after completion
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] e;
    launch_valid_i = 1'b1; launch_op_i = op; launch_a_i = a; launch_b_i = b;
    dec_reads_hilo_i = 1'b1;
    #1 chk("R5 launch-cycle stall", 64'(stall_o), 64'd1);
    dec_reads_hilo_i = 1'b0;
    #0 chk("R6 launch without read", 64'(stall_o), 64'd0);
    @(negedge clk_i);
    launch_valid_i = 1'b0;
    chk("R4 busy rise", 64'(busy_o), 64'd1);
    dec_reads_hilo_i = 1'b1;
    #1 chk("R5 busy stall", 64'(stall_o), 64'd1);
    dec_reads_hilo_i = 1'b0;
    repeat (32) @(negedge clk_i);
    chk("R4 busy last cycle", 64'(busy_o), 64'd1);
    chk("R4 hold before done", {hi_o, lo_o}, {exp_hi, exp_lo});
    @(negedge clk_i);
    chk("R4 busy fall", 64'(busy_o), 64'd0);
    e = model(op, a, b);
    exp_hi = e[63:32];
    exp_lo = e[31:0];
    chk(req_of(op, b), {hi_o, lo_o}, e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] vals [10];
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
             32'd7, 32'hFFFF_FFF9, 32'd3, 32'h0BC6_14E0, 32'hFFF0_EDBA};
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 busy", 64'(busy_o), 64'd0);
    chk("R8 hilo", {hi_o, lo_o}, 64'd0);
    dec_reads_hilo_i = 1'b1;
    #1 chk("R8 stall", 64'(stall_o), 64'd0);
    dec_reads_hilo_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 after release", {63'd0, busy_o}, 64'd0);
    dec_reads_hilo_i = 1'b1;
    #1 chk("R8 idle read no stall", 64'(stall_o), 64'd0);
    dec_reads_hilo_i = 1'b0;

    // R1 R2 R3 sweep over corner operands
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(2'(op), vals[i], vals[j]);

    dec_reads_hilo_i = 1'b1;
    #1 chk("R5 idle after op", 64'(stall_o), 64'd0);
    dec_reads_hilo_i = 1'b0;

    // R7 restart mid-operation
    launch_valid_i = 1'b1; launch_op_i = 2'b01; launch_a_i = 32'd99; launch_b_i = 32'd77;
    @(negedge clk_i);
    launch_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R7 old hilo during abort", {hi_o, lo_o}, {exp_hi, exp_lo});
    run_op(2'b10, 32'hFFFF_FF9C, 32'd7);

    // R7 restart in the final cycle
    launch_valid_i = 1'b1; launch_op_i = 2'b11; launch_a_i = 32'd1000; launch_b_i = 32'd3;
    @(negedge clk_i);
    launch_valid_i = 1'b0;
    repeat (32) @(negedge clk_i);
    chk("R7 final cycle busy", 64'(busy_o), 64'd1);
    run_op(2'b00, 32'h1234_5678, 32'hFFFF_FFFE);

    summary();
  end
endmodule